// File: doc/BRIEF.md
# Dual-Pipeline Indexed Register Write Steering

This block sits between the host I/O write path and two copies of a display controller's indexed register groups. Each display pipeline, A and B, has one copy of a palette group and one copy of an attribute group. A two-bit steering register selects which pipeline's copies accept host writes. The choices are neither, A alone, B alone, or both at once. A blocked pipeline ignores every host write. Its index registers are held off in the same way as its data registers.

The attribute group is reached through a single port that alternates between index and data. Each pipeline keeps its own phase bit for that alternation. A pipeline whose lock input is high keeps its attribute port as an index-only register. A read of a pipeline's input-status register returns the phase to index, and which pipelines it affects depends on the steering mode. The palette group has separate index and data ports. The palette index steps forward after each data write.

The outputs are a write strobe, an address and data for each group of each pipeline, plus each pipeline's current attribute phase. The storage behind those strobes lies outside this block.

Top module: `idx_write_steer`

## Requirements
- R1: After reset both attribute phases read index (0), every attribute and palette address reads zero, and the steering register holds 00, so no write strobe is asserted until the steering register is loaded.
- R2: Steering bit 0 enables pipeline A and bit 1 enables pipeline B (00 none, 01 A only, 10 B only, 11 both). A value presented with `steerWe` governs writes from the following cycle onward.
- R3: A host write on any port to a pipeline that the steering register blocks raises none of that pipeline's strobes and leaves its attribute index, palette index and phase unchanged.
- R4: For an enabled, unlocked pipeline, an attribute-port write (`portSel` = 00) in index phase loads the attribute index from the low bits of `wrData` and moves to data phase. A write in data phase raises the attribute strobe in that same cycle, with the stored index as address and `wrData` as data, and moves back to index phase.
- R5: While a pipeline's lock input is high, its phase reads index and its attribute strobe stays low. Every enabled attribute-port write loads its index.
- R6: In modes 01 and 10, a status-read strobe of the enabled pipeline returns that pipeline to index phase. The status-read strobe of the blocked pipeline changes nothing.
- R7: In mode 11, a status-read strobe of either pipeline returns both pipelines to index phase.
- R8: If a status read and an attribute-port write arrive in the same cycle, the write acts according to the phase that held before the edge, and the pipeline still ends in index phase.
- R9: A palette index write (`portSel` = 01) loads the palette address from the low bits of `wrData`. A palette data write (`portSel` = 10) raises the palette strobe in the same cycle, with the current palette address and `wrData`, and the address then increments modulo 2^PW.
- R10: Palette-port traffic never changes an attribute phase or an attribute index. Attribute-port traffic never changes a palette address.
- R11: In mode 11 a single host write drives both pipelines in the same cycle with the same data, and each pipeline follows its own phase and lock.
- R12: A write with `portSel` = 11 changes no state and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| steerWe | input | 1 | Load strobe for the steering register |
| steerIn | input | 2 | New steering value (bit 0 = A, bit 1 = B) |
| lockA | input | 1 | Pipeline A attribute-port lock |
| lockB | input | 1 | Pipeline B attribute-port lock |
| wrStb | input | 1 | Host I/O write strobe |
| portSel | input | 2 | 00 attribute, 01 palette index, 10 palette data, 11 unused |
| wrData | input | DW | Host write data |
| statRdA | input | 1 | Pipeline A input-status read strobe |
| statRdB | input | 1 | Pipeline B input-status read strobe |
| attrWeA | output | 1 | Pipeline A attribute register write strobe |
| attrAddrA | output | AW | Pipeline A attribute index |
| attrDataA | output | DW | Pipeline A attribute write data |
| palWeA | output | 1 | Pipeline A palette write strobe |
| palAddrA | output | PW | Pipeline A palette index |
| palDataA | output | DW | Pipeline A palette write data |
| phaseA | output | 1 | Pipeline A attribute phase (1 = data) |
| attrWeB | output | 1 | Pipeline B attribute register write strobe |
| attrAddrB | output | AW | Pipeline B attribute index |
| attrDataB | output | DW | Pipeline B attribute write data |
| palWeB | output | 1 | Pipeline B palette write strobe |
| palAddrB | output | PW | Pipeline B palette index |
| palDataB | output | DW | Pipeline B palette write data |
| phaseB | output | 1 | Pipeline B attribute phase (1 = data) |

## Verification
The checker holds on every cycle the properties that follow from a single edge. These are: blocked pipelines stay silent and frozen, a locked port never shows data phase, every attribute data write returns the port to index phase, palette data writes step the address by one, status reads clear the right pipelines for the current mode, and palette traffic leaves the phases alone. What depends on history needs the bench's sweeps, in which a reference model follows the phase, both indices and the steering value through every mode, lock pair, port and status-read combination. That history includes which index a data write lands on, a change of mode with a pipeline left in data phase, and the wrap of the palette address.

// File: rtl/iws_pkg.sv
package iws_pkg;

  typedef enum logic [1:0] {
    PORT_ATTR     = 2'b00,
    PORT_PAL_IDX  = 2'b01,
    PORT_PAL_DATA = 2'b10,
    PORT_NONE     = 2'b11
  } port_e;

  // per-pipeline strobes from control to datapath
  typedef struct packed {
    logic attrIdxLd;
    logic attrDataWe;
    logic palIdxLd;
    logic palDataWe;
  } strobe_t;

endpackage

// File: rtl/iws_ctrl.sv
module iws_ctrl #(
  parameter int NPIPE = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         steerWe,
  input  logic [NPIPE-1:0]             steerIn,
  input  logic [NPIPE-1:0]             lock,
  input  logic                         wrStb,
  input  logic [1:0]                   portSel,
  input  logic [NPIPE-1:0]             statRd,
  output iws_pkg::strobe_t [NPIPE-1:0] stb,
  output logic [NPIPE-1:0]             phase
);
  import iws_pkg::*;

  port_e            sel;
  logic [NPIPE-1:0] steerQ;
  logic [NPIPE-1:0] ffQ;
  logic [NPIPE-1:0] ffNext;
  logic [NPIPE-1:0] phaseInt;
  logic [NPIPE-1:0] attrWr;
  logic [NPIPE-1:0] clr;
  logic             statHit;

  assign sel = port_e'(portSel);

  // steering register: one enable bit per pipeline
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        steerQ <= '0;
    else if (steerWe) steerQ <= steerIn;
  end

  // a status read counts only when it targets an enabled pipeline
  assign statHit = |(statRd & steerQ);

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    assign phaseInt[p] = ffQ[p] & ~lock[p];
    assign attrWr[p]   = wrStb & steerQ[p] & (sel == PORT_ATTR);
    assign clr[p]      = steerQ[p] & statHit;

    assign stb[p].attrIdxLd  = attrWr[p] & ~phaseInt[p];
    assign stb[p].attrDataWe = attrWr[p] &  phaseInt[p];
    assign stb[p].palIdxLd   = wrStb & steerQ[p] & (sel == PORT_PAL_IDX);
    assign stb[p].palDataWe  = wrStb & steerQ[p] & (sel == PORT_PAL_DATA);
  end

  // phase update: status-read clear wins over the toggle
  always_comb begin
    ffNext = ffQ;
    for (int p = 0; p < NPIPE; p++) begin
      if (clr[p])         ffNext[p] = 1'b0;
      else if (attrWr[p]) ffNext[p] = ~lock[p] & ~phaseInt[p];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ffQ <= '0;
    else       ffQ <= ffNext;
  end

  assign phase = phaseInt;

endmodule

// File: rtl/iws_path.sv
module iws_path #(
  parameter int AW = 5,
  parameter int PW = 8,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  iws_pkg::strobe_t stb,
  input  logic [DW-1:0]    wrData,
  output logic             attrWe,
  output logic [AW-1:0]    attrAddr,
  output logic [DW-1:0]    attrData,
  output logic             palWe,
  output logic [PW-1:0]    palAddr,
  output logic [DW-1:0]    palData
);

  logic [AW-1:0] attrIdxQ;
  logic [PW-1:0] palIdxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              attrIdxQ <= '0;
    else if (stb.attrIdxLd) attrIdxQ <= wrData[AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              palIdxQ <= '0;
    else if (stb.palIdxLd)  palIdxQ <= wrData[PW-1:0];
    else if (stb.palDataWe) palIdxQ <= palIdxQ + 1'b1;
  end

  assign attrWe   = stb.attrDataWe;
  assign attrAddr = attrIdxQ;
  assign attrData = wrData;
  assign palWe    = stb.palDataWe;
  assign palAddr  = palIdxQ;
  assign palData  = wrData;

endmodule

// File: rtl/idx_write_steer.sv
module idx_write_steer #(
  parameter int AW = 5,
  parameter int PW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          steerWe,
  input  logic [1:0]    steerIn,
  input  logic          lockA,
  input  logic          lockB,
  input  logic          wrStb,
  input  logic [1:0]    portSel,
  input  logic [DW-1:0] wrData,
  input  logic          statRdA,
  input  logic          statRdB,
  output logic          attrWeA,
  output logic [AW-1:0] attrAddrA,
  output logic [DW-1:0] attrDataA,
  output logic          palWeA,
  output logic [PW-1:0] palAddrA,
  output logic [DW-1:0] palDataA,
  output logic          phaseA,
  output logic          attrWeB,
  output logic [AW-1:0] attrAddrB,
  output logic [DW-1:0] attrDataB,
  output logic          palWeB,
  output logic [PW-1:0] palAddrB,
  output logic [DW-1:0] palDataB,
  output logic          phaseB
);
  localparam int NPIPE = 2;

  iws_pkg::strobe_t [NPIPE-1:0] stb;
  logic [NPIPE-1:0]             phase;
  logic [NPIPE-1:0]             attrWe;
  logic [NPIPE-1:0]             palWe;
  logic [AW-1:0]                attrAddr [NPIPE];
  logic [DW-1:0]                attrData [NPIPE];
  logic [PW-1:0]                palAddr  [NPIPE];
  logic [DW-1:0]                palData  [NPIPE];

  iws_ctrl #(.NPIPE(NPIPE)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .steerWe (steerWe),
    .steerIn (steerIn),
    .lock    ({lockB, lockA}),
    .wrStb   (wrStb),
    .portSel (portSel),
    .statRd  ({statRdB, statRdA}),
    .stb     (stb),
    .phase   (phase)
  );

  for (genvar p = 0; p < NPIPE; p++) begin : g_path
    iws_path #(.AW(AW), .PW(PW), .DW(DW)) u_path (
      .clk      (clk),
      .rstN     (rstN),
      .stb      (stb[p]),
      .wrData   (wrData),
      .attrWe   (attrWe[p]),
      .attrAddr (attrAddr[p]),
      .attrData (attrData[p]),
      .palWe    (palWe[p]),
      .palAddr  (palAddr[p]),
      .palData  (palData[p])
    );
  end

  assign attrWeA   = attrWe[0];
  assign attrAddrA = attrAddr[0];
  assign attrDataA = attrData[0];
  assign palWeA    = palWe[0];
  assign palAddrA  = palAddr[0];
  assign palDataA  = palData[0];
  assign phaseA    = phase[0];
  assign attrWeB   = attrWe[1];
  assign attrAddrB = attrAddr[1];
  assign attrDataB = attrData[1];
  assign palWeB    = palWe[1];
  assign palAddrB  = palAddr[1];
  assign palDataB  = palData[1];
  assign phaseB    = phase[1];

endmodule

// File: rtl/iws_chk.sv
module iws_chk #(
  parameter int AW = 5,
  parameter int PW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          steerWe,
  input logic [1:0]    steerIn,
  input logic          lockA,
  input logic          lockB,
  input logic          wrStb,
  input logic [1:0]    portSel,
  input logic          statRdA,
  input logic          statRdB,
  input logic          attrWeA,
  input logic          attrWeB,
  input logic [AW-1:0] attrAddrA,
  input logic [AW-1:0] attrAddrB,
  input logic          palWeA,
  input logic          palWeB,
  input logic [PW-1:0] palAddrA,
  input logic [PW-1:0] palAddrB,
  input logic [DW-1:0] palDataA,
  input logic [DW-1:0] palDataB,
  input logic          phaseA,
  input logic          phaseB
);
  // checker's own view of the steering mode
  logic [1:0] modeQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        modeQ <= 2'b00;
    else if (steerWe) modeQ <= steerIn;
  end

  // R3
  blocked_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ[0] |-> !attrWeA && !palWeA);
  // R3
  frozen_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ[0] |=> $stable(attrAddrA) && $stable(palAddrA) && $stable(phaseA));
  // R3
  frozen_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ[1] |=> $stable(attrAddrB) && $stable(palAddrB) && $stable(phaseB));
  // R2
  pal_steer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && portSel == 2'b10) |-> (palWeA == modeQ[0]) && (palWeB == modeQ[1]));
  // R4
  data_back_to_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (attrWeA || attrWeB) |=> (!phaseA || !$past(attrWeA)) && (!phaseB || !$past(attrWeB)));
  // R5
  lock_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockA |-> !phaseA && !attrWeA);
  // R5
  lock_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockB |-> !phaseB && !attrWeB);
  // R6
  stat_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[0] && statRdA) |=> !phaseA);
  // R7
  stat_bcast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b11 && (statRdA || statRdB)) |=> !phaseA && !phaseB);
  // R9
  pal_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    palWeA |=> palAddrA == PW'($past(palAddrA) + 1'b1));
  // R10
  pal_keeps_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && portSel != 2'b00 && !statRdA && !statRdB)
      |=> $stable(phaseA) && $stable(phaseB) && $stable(attrAddrA) && $stable(attrAddrB));
  // R11
  bcast_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b11 && wrStb && portSel == 2'b10) |-> palWeA && palWeB && palDataA == palDataB);
  // R12
  unused_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && portSel == 2'b11) |=> $stable(palAddrA) && $stable(palAddrB));

endmodule

bind idx_write_steer iws_chk #(.AW(AW), .PW(PW), .DW(DW)) u_iws_chk (
  .clk       (clk),
  .rstN      (rstN),
  .steerWe   (steerWe),
  .steerIn   (steerIn),
  .lockA     (lockA),
  .lockB     (lockB),
  .wrStb     (wrStb),
  .portSel   (portSel),
  .statRdA   (statRdA),
  .statRdB   (statRdB),
  .attrWeA   (attrWeA),
  .attrWeB   (attrWeB),
  .attrAddrA (attrAddrA),
  .attrAddrB (attrAddrB),
  .palWeA    (palWeA),
  .palWeB    (palWeB),
  .palAddrA  (palAddrA),
  .palAddrB  (palAddrB),
  .palDataA  (palDataA),
  .palDataB  (palDataB),
  .phaseA    (phaseA),
  .phaseB    (phaseB)
);

// File: tb/test_idx_write_steer.sv
module test_idx_write_steer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int PW = 3;
  localparam int DW = 4;
  localparam int VW = 1 + AW + DW + 1 + PW + DW + 1;

  logic          clk = 1'b0;
  logic          rstN;
  logic          steerWe, lockA, lockB, wrStb, statRdA, statRdB;
  logic [1:0]    steerIn, portSel;
  logic [DW-1:0] wrData;
  logic          attrWeA, palWeA, phaseA, attrWeB, palWeB, phaseB;
  logic [AW-1:0] attrAddrA, attrAddrB;
  logic [PW-1:0] palAddrA, palAddrB;
  logic [DW-1:0] attrDataA, palDataA, attrDataB, palDataB;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_write_steer #(.AW(AW), .PW(PW), .DW(DW)) i_idx_write_steer (
    .clk(clk), .rstN(rstN), .steerWe(steerWe), .steerIn(steerIn),
    .lockA(lockA), .lockB(lockB), .wrStb(wrStb), .portSel(portSel),
    .wrData(wrData), .statRdA(statRdA), .statRdB(statRdB),
    .attrWeA(attrWeA), .attrAddrA(attrAddrA), .attrDataA(attrDataA),
    .palWeA(palWeA), .palAddrA(palAddrA), .palDataA(palDataA), .phaseA(phaseA),
    .attrWeB(attrWeB), .attrAddrB(attrAddrB), .attrDataB(attrDataB),
    .palWeB(palWeB), .palAddrB(palAddrB), .palDataB(palDataB), .phaseB(phaseB)
  );

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  // reference state, derived from the requirements
  logic [1:0]    mMode;
  logic [1:0]    mFf;
  logic [1:0]    mLk;
  logic [AW-1:0] mAIdx [2];
  logic [PW-1:0] mPIdx [2];

  task automatic step(input logic sw, input logic [1:0] swv, input logic wr,
                      input logic [1:0] sel, input logic [DW-1:0] d,
                      input logic sa, input logic sb, input string tag);
    logic [VW-1:0] act [2];
    logic [VW-1:0] exp [2];
    logic          hit;
    @(negedge clk);
    steerWe = sw; steerIn = swv; wrStb = wr; portSel = sel; wrData = d;
    statRdA = sa; statRdB = sb; lockA = mLk[0]; lockB = mLk[1];
    #1;
    act[0] = {attrWeA, attrAddrA, attrDataA, palWeA, palAddrA, palDataA, phaseA};
    act[1] = {attrWeB, attrAddrB, attrDataB, palWeB, palAddrB, palDataB, phaseB};
    hit = (sa && mMode[0]) || (sb && mMode[1]);
    for (int p = 0; p < 2; p++) begin
      logic en, ph, aw;
      en = mMode[p];
      ph = mFf[p] & ~mLk[p];
      aw = wr && sel == 2'b00 && en;
      exp[p] = {aw && ph, mAIdx[p], d, wr && sel == 2'b10 && en, mPIdx[p], d, ph};
      nRun++;
      if (act[p] !== exp[p]) begin
        nFail++;
        $display("FAIL %s pipe%0d: actual=%h expected=%h", tag, p, act[p], exp[p]);
      end
      if (aw && !ph) mAIdx[p] = d[AW-1:0];
      if (en && hit)  mFf[p] = 1'b0;
      else if (aw)    mFf[p] = !mLk[p] && !ph;
      if (wr && sel == 2'b01 && en)      mPIdx[p] = d[PW-1:0];
      else if (wr && sel == 2'b10 && en) mPIdx[p] = mPIdx[p] + 1'b1;
    end
    if (sw) mMode = swv;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; steerWe = 0; steerIn = 0; lockA = 0; lockB = 0; wrStb = 0;
    portSel = 0; wrData = 0; statRdA = 0; statRdB = 0;
    mMode = 0; mFf = 0; mLk = 0;
    mAIdx[0] = 0; mAIdx[1] = 0; mPIdx[0] = 0; mPIdx[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state, writes blocked before steering is loaded
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 1, 2'b00, 4'h5, 0, 0, "R1");
    step(0, 0, 1, 2'b10, 4'h5, 0, 0, "R1");
    // R2: each steering value
    step(1, 2'b01, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 1, 2'b10, 4'h3, 0, 0, "R2");
    step(1, 2'b10, 1, 2'b10, 4'h4, 0, 0, "R2");
    step(0, 0, 1, 2'b10, 4'h6, 0, 0, "R2");
    // R3: A blocked in mode 10
    step(0, 0, 1, 2'b00, 4'h2, 0, 0, "R3");
    step(0, 0, 1, 2'b01, 4'h7, 0, 0, "R3");
    // R4: index then data on A
    step(1, 2'b01, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 1, 2'b00, 4'h5, 0, 0, "R4");
    step(0, 0, 1, 2'b00, 4'h9, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, "R4");
    // R5: lock on A
    mLk = 2'b01;
    step(0, 0, 1, 2'b00, 4'h3, 0, 0, "R5");
    step(0, 0, 1, 2'b00, 4'h6, 0, 0, "R5");
    mLk = 2'b00;
    // R6: only the enabled pipeline's status read counts
    step(0, 0, 1, 2'b00, 4'h1, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, "R6");
    step(0, 0, 0, 0, 0, 1, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, "R6");
    // R7: broadcast clear
    step(1, 2'b11, 1, 2'b00, 4'h2, 0, 0, "R7");
    step(0, 0, 1, 2'b00, 4'h4, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    // R8: status read together with a data write
    step(0, 0, 1, 2'b00, 4'h6, 0, 0, "R8");
    step(0, 0, 1, 2'b00, 4'hA, 1, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    // R9: palette load, data writes, wrap
    step(0, 0, 1, 2'b01, 4'h6, 0, 0, "R9");
    step(0, 0, 1, 2'b10, 4'hB, 0, 0, "R9");
    step(0, 0, 1, 2'b10, 4'hC, 0, 0, "R9");
    step(0, 0, 1, 2'b10, 4'hD, 0, 0, "R9");
    // R10: palette traffic while in data phase
    step(0, 0, 1, 2'b00, 4'h3, 0, 0, "R10");
    step(0, 0, 1, 2'b10, 4'h8, 0, 0, "R10");
    step(0, 0, 1, 2'b01, 4'h2, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    // R11: one write, both pipelines, B locked
    mLk = 2'b10;
    step(0, 0, 1, 2'b00, 4'hF, 0, 0, "R11");
    step(0, 0, 1, 2'b10, 4'h9, 0, 0, "R11");
    mLk = 2'b00;
    // R12: unused port select
    step(0, 0, 1, 2'b11, 4'h7, 0, 0, "R12");
    step(0, 0, 0, 0, 0, 0, 0, "R12");

    // sweep: every mode, lock pair, port, status pair and data value
    for (int m = 0; m < 4; m++) begin
      step(1, 2'(m), 0, 0, 0, 0, 0, "R2 sweep");
      for (int l = 0; l < 4; l++) begin
        mLk = 2'(l);
        for (int s = 0; s < 4; s++) begin
          for (int r = 0; r < 4; r++) begin
            for (int d = 0; d < 8; d++) begin
              step(0, 0, 1, 2'b00, DW'(d), 0, 0, "R3 sweep");
              step(0, 0, 1, 2'(s), DW'(d ^ 5), r[0], r[1], "R3 sweep");
            end
          end
        end
      end
    end
    mLk = 2'b00;
    step(0, 0, 0, 0, 0, 0, 0, "R1 idle");
    finishRun();
  end

endmodule